// File: doc/BRIEF.md
# Bus Mastership Arbiter Interface

This block sits on the master side of a shared external bus that is arbitrated with a grant input and an open-drain, active-low busy line. The busy line appears as three signals: a sampled input, a drive value and an output enable. The block takes the bus when grant is present and the busy line reads released. It keeps the bus while grant stays present, even with no pending work, so the next access needs no new arbitration. When grant goes away it releases the bus at the end of the bus cycle in progress. To release, it drives busy high for one clock and then tri-states the line, and an external pull-up keeps it high from there.

The access engine asks for a bus cycle with a valid/ready pair. A cycle starts on the clock edge where `req_valid_i` and `req_ready_o` are both high. It stays open until the engine pulses `cyc_done_i`. Only one cycle may be open at a time. `req_ready_o` is high only while the block owns the bus, grant is seen present and no cycle is open. The engine holds `req_valid_i` until it sees ready, and may withdraw it at any time before a handshake. The `own_o` flag is meant to gate the address, data and strobe output enables. A mode input selects how grant and busy are sampled: directly on the clock, or through internal synchronizer chains. In the synchronized mode a hold-off window after each release ignores a new grant. A system without arbitration ties grant high.

Top module: `bus_master_arbiter`

## Requirements
- R1: Ownership is taken only on a clock edge where the effective grant is high and the effective busy input reads 1 (released). When ownership is taken, `busy_oe_o`=1, `busy_n_o`=0 and `own_o`=1 from the next cycle on. While another master holds busy at 0, ownership is never taken.
- R2: When grant is removed while a bus cycle is open, ownership is kept until the clock edge on which `cyc_done_i` is high. The release starts on that edge.
- R3: While grant stays high, ownership is kept whatever `req_valid_i` shows (parking).
- R4: A release is exactly one cycle with `busy_oe_o`=1, `busy_n_o`=1 and `own_o`=0. The cycle after it has `busy_oe_o`=0.
- R5: With `sync_mode_i`=0, a change on grant or busy acts on the next clock edge, so outputs change one cycle later. With `sync_mode_i`=1 (SYNC_STAGES=2), outputs change three cycles after the input change.
- R6: With `sync_mode_i`=1, after the edge that starts a release, no ownership is taken before GRANT_GAP+1 further edges (default 4, so the earliest take is on the fifth edge). With `sync_mode_i`=0 there is no hold-off.
- R7: `req_ready_o` is high only when the block owns the bus, grant is seen present and no cycle is open. After a handshake, ready stays low until the cycle is closed.
- R8: During reset (`rst_n`=0, asynchronous), `busy_oe_o`, `own_o` and `req_ready_o` are 0 whatever grant shows. This also applies when reset arrives while the block owns the bus.
- R9: Busy is driven low only while `own_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_mode_i | input | 1 | 1 selects synchronizer chains on grant and busy; change only while not owning |
| grant_i | input | 1 | Grant from the external arbiter, active high |
| busy_n_i | input | 1 | Sampled level of the shared busy line, 0 = busy |
| busy_oe_o | output | 1 | Output enable of the busy line driver |
| busy_n_o | output | 1 | Value driven on the busy line when enabled |
| own_o | output | 1 | Bus owner flag, gates the other output enables |
| req_valid_i | input | 1 | Access engine asks to start a bus cycle |
| req_ready_o | output | 1 | A bus cycle may start this cycle |
| cyc_done_i | input | 1 | Open bus cycle ends on this edge |

## Verification
If the state register is corrupted, the busy line shows it within a single cycle. An owner state drives `busy_n_o` low, a release state shows a lone high drive, and idle tri-states the line. So a missed release, a doubled release or an early take is visible as a wrong `busy_oe_o`/`busy_n_o` pair in the very cycle it happens. A stale open-cycle flag shows up in two ways: `req_ready_o` stays low while parked, or the release comes before `cyc_done_i`. A wrong hold-off count shows as ownership one or more cycles too early or too late after a re-grant in synchronized mode. The scoreboard states the cycle number of every expected output, so each of these appears as an exact-cycle mismatch.

// File: rtl/bm_pkg.sv
package bm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_OWN  = 2'd1,
    ST_REL  = 2'd2
  } bm_state_e;
endpackage

// File: rtl/bm_sync.sv
module bm_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= RST_VAL;
        else        sr <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= {STAGES{RST_VAL}};
        else        sr <= {sr[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sr[STAGES-1];
endmodule

// File: rtl/bm_holdoff.sv
module bm_holdoff #(
  parameter int GAP = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic clear_o
);
  generate
    if (GAP == 0) begin : g_none
      assign clear_o = 1'b1;
    end else begin : g_cnt
      localparam int CW = $clog2(GAP + 1);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt <= '0;
        else if (load_i)       cnt <= CW'(GAP);
        else if (cnt != '0)    cnt <= cnt - 1'b1;
      end
      assign clear_o = (cnt == '0);
    end
  endgenerate
endmodule

// File: rtl/bm_fsm.sv
module bm_fsm
  import bm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic grant_s_i,
  input  logic free_s_i,
  input  logic gap_clear_i,
  input  logic req_valid_i,
  input  logic cyc_done_i,
  output logic own_o,
  output logic busy_oe_o,
  output logic busy_n_o,
  output logic req_ready_o,
  output logic rel_start_o
);
  bm_state_e state, state_nx;
  logic      in_cyc;
  logic      hs;

  assign req_ready_o = (state == ST_OWN) && grant_s_i && !in_cyc;
  assign hs          = req_valid_i && req_ready_o;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE: if (grant_s_i && free_s_i && gap_clear_i) state_nx = ST_OWN;
      ST_OWN:  if (!grant_s_i && (!in_cyc || cyc_done_i)) state_nx = ST_REL;
      ST_REL:  state_nx = ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      in_cyc <= 1'b0;
    end else begin
      state <= state_nx;
      if (hs)              in_cyc <= 1'b1;
      else if (cyc_done_i) in_cyc <= 1'b0;
    end
  end

  assign rel_start_o = (state == ST_OWN) && (state_nx == ST_REL);
  assign own_o       = (state == ST_OWN);
  assign busy_oe_o   = (state != ST_IDLE);
  assign busy_n_o    = (state != ST_OWN);
endmodule

// File: rtl/bus_master_arbiter.sv
module bus_master_arbiter #(
  parameter int SYNC_STAGES = 2,
  parameter int GRANT_GAP   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_mode_i,
  input  logic grant_i,
  input  logic busy_n_i,
  output logic busy_oe_o,
  output logic busy_n_o,
  output logic own_o,
  input  logic req_valid_i,
  output logic req_ready_o,
  input  logic cyc_done_i
);
  logic grant_sy, free_sy;
  logic grant_eff, free_eff;
  logic gap_clear, rel_start;

  bm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_grant_sync (
    .clk(clk), .rst_n(rst_n), .d_i(grant_i), .q_o(grant_sy)
  );

  bm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_busy_sync (
    .clk(clk), .rst_n(rst_n), .d_i(busy_n_i), .q_o(free_sy)
  );

  assign grant_eff = sync_mode_i ? grant_sy : grant_i;
  assign free_eff  = sync_mode_i ? free_sy  : busy_n_i;

  bm_holdoff #(.GAP(GRANT_GAP)) u_gap (
    .clk(clk), .rst_n(rst_n),
    .load_i(rel_start && sync_mode_i),
    .clear_o(gap_clear)
  );

  bm_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .grant_s_i(grant_eff), .free_s_i(free_eff), .gap_clear_i(gap_clear),
    .req_valid_i(req_valid_i), .cyc_done_i(cyc_done_i),
    .own_o(own_o), .busy_oe_o(busy_oe_o), .busy_n_o(busy_n_o),
    .req_ready_o(req_ready_o), .rel_start_o(rel_start)
  );
endmodule

// File: rtl/bm_arbiter_chk.sv
module bm_arbiter_chk #(
  parameter int GRANT_GAP = 4
) (
  input logic clk,
  input logic rst_n,
  input logic sync_mode_i,
  input logic grant_i,
  input logic busy_n_i,
  input logic busy_oe_o,
  input logic busy_n_o,
  input logic own_o,
  input logic req_valid_i,
  input logic req_ready_o
);
  localparam int GW = $clog2(GRANT_GAP + 2) + 1;
  logic [GW-1:0] gap_cnt;
  logic          own_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_cnt <= '1;
      own_d   <= 1'b0;
    end else begin
      own_d <= own_o;
      if (own_d && !own_o)    gap_cnt <= GW'(1);
      else if (gap_cnt != '1) gap_cnt <= gap_cnt + 1'b1;
    end
  end

  p_take_when_free_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_mode_i && !$past(sync_mode_i) && $rose(own_o)) |-> ($past(grant_i) && $past(busy_n_i)));

  p_release_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(own_o) |-> (busy_oe_o && busy_n_o));

  p_release_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_oe_o && busy_n_o) |=> !busy_oe_o);

  p_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode_i && $past(sync_mode_i) && $rose(own_o)) |-> (gap_cnt > GW'(GRANT_GAP)));

  p_ready_owner_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready_o |-> own_o);

  p_one_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  p_low_drive_owner_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_oe_o && !busy_n_o) |-> own_o);
endmodule

bind bus_master_arbiter bm_arbiter_chk #(.GRANT_GAP(GRANT_GAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_mode_i(sync_mode_i), .grant_i(grant_i),
  .busy_n_i(busy_n_i), .busy_oe_o(busy_oe_o), .busy_n_o(busy_n_o),
  .own_o(own_o), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o)
);

// File: tb/sim_bus_master_arbiter.sv
`timescale 1ns/1ps
module sim_bus_master_arbiter;
  logic clk = 1'b0;
  logic rst_n, sync_mode_i, grant_i, ext_busy_n, req_valid_i, cyc_done_i;
  logic busy_n_i, busy_oe_o, busy_n_o, own_o, req_ready_o;
  int   cyc = 0;
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   finished = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // shared line: our driver when enabled, otherwise the other master / pull-up
  assign busy_n_i = busy_oe_o ? busy_n_o : ext_busy_n;

  bus_master_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .sync_mode_i(sync_mode_i), .grant_i(grant_i),
    .busy_n_i(busy_n_i), .busy_oe_o(busy_oe_o), .busy_n_o(busy_n_o),
    .own_o(own_o), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .cyc_done_i(cyc_done_i)
  );

  typedef struct {
    int    at;
    logic  own;
    logic  oe;
    logic  drv;
    logic  rdy;
    string tag;
  } exp_t;
  exp_t sb[$];

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic expect_at(input int d, input logic own, input logic oe,
                           input logic drv, input logic rdy, input string tag);
    exp_t e;
    e.at = cyc + d; e.own = own; e.oe = oe; e.drv = drv; e.rdy = rdy; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: compare expectations for this cycle, away from the edge
  always @(negedge clk) begin
    for (int i = 0; i < sb.size(); ) begin
      if (sb[i].at == cyc) begin
        n_cmp++;
        if (own_o !== sb[i].own || busy_oe_o !== sb[i].oe || req_ready_o !== sb[i].rdy ||
            (sb[i].oe && busy_n_o !== sb[i].drv)) begin
          n_bad++;
          $display("FAIL %s cyc=%0d own=%b/%b oe=%b/%b drv=%b/%b rdy=%b/%b (actual/expected)",
                   sb[i].tag, cyc, own_o, sb[i].own, busy_oe_o, sb[i].oe,
                   busy_n_o, sb[i].drv, req_ready_o, sb[i].rdy);
        end
        sb.delete(i);
      end else begin
        i++;
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired at cyc=%0d", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sync_mode_i = 1'b0; grant_i = 1'b1; ext_busy_n = 1'b0;
    req_valid_i = 1'b0; cyc_done_i = 1'b0;
    tick(); tick();
    expect_at(0, 0, 0, 0, 0, "R8 reset with grant high");
    tick();
    // direct mode, another master holds busy low
    rst_n = 1'b1;
    expect_at(1, 0, 0, 0, 0, "R1 busy held by other");
    expect_at(2, 0, 0, 0, 0, "R1 busy held by other");
    tick(); tick();
    ext_busy_n = 1'b1;
    expect_at(0, 0, 0, 0, 0, "R5 direct not yet");
    expect_at(1, 1, 1, 0, 1, "R1 take when free");
    tick();
    // parking: no request, grant stays
    for (int k = 0; k < 5; k++) begin
      tick();
      expect_at(0, 1, 1, 0, 1, "R3 parked");
    end
    // handshake then grant removal mid-cycle
    tick();
    req_valid_i = 1'b1;
    expect_at(0, 1, 1, 0, 1, "R7 ready before start");
    tick();
    req_valid_i = 1'b0; grant_i = 1'b0;
    expect_at(0, 1, 1, 0, 0, "R7 ready low while open");
    expect_at(1, 1, 1, 0, 0, "R2 kept during open cycle");
    tick(); tick();
    cyc_done_i = 1'b1;
    expect_at(0, 1, 1, 0, 0, "R2 kept until done edge");
    expect_at(1, 0, 1, 1, 0, "R4 release drives high");
    expect_at(2, 0, 0, 1, 0, "R4 tri-state after release");
    tick();
    cyc_done_i = 1'b0;
    tick(); tick();
    // direct re-grant: no hold-off, one-cycle latency
    grant_i = 1'b1;
    expect_at(1, 1, 1, 0, 1, "R5 direct one-cycle take");
    tick(); tick();
    grant_i = 1'b0;
    expect_at(1, 0, 1, 1, 0, "R4 release without open cycle");
    tick(); tick();
    grant_i = 1'b1;
    expect_at(1, 1, 1, 0, 1, "R6 no hold-off in direct mode");
    tick(); tick();
    grant_i = 1'b0;
    tick(); tick();
    // synchronized mode
    sync_mode_i = 1'b1;
    tick(); tick(); tick();
    grant_i = 1'b1;
    expect_at(1, 0, 0, 0, 0, "R5 sync latency");
    expect_at(2, 0, 0, 0, 0, "R5 sync latency");
    expect_at(3, 1, 1, 0, 1, "R5 sync take after three");
    tick(); tick(); tick(); tick(); tick();
    grant_i = 1'b0;
    expect_at(2, 1, 1, 0, 0, "R5 sync release latency");
    expect_at(3, 0, 1, 1, 0, "R4 sync release");
    expect_at(4, 0, 0, 1, 0, "R4 sync tri-state");
    tick(); tick(); tick(); tick();
    grant_i = 1'b1;
    expect_at(3, 0, 0, 0, 0, "R6 held off");
    expect_at(4, 1, 1, 0, 1, "R6 take after gap");
    for (int k = 0; k < 8; k++) tick();
    // synchronized mode with busy held by another master
    grant_i = 1'b0;
    tick(); tick(); tick(); tick();
    ext_busy_n = 1'b0; grant_i = 1'b1;
    for (int k = 0; k < 10; k++) begin
      tick();
      expect_at(0, 0, 0, 0, 0, "R1 sync busy held");
    end
    ext_busy_n = 1'b1;
    expect_at(2, 0, 0, 0, 0, "R1 sync wait for free");
    expect_at(3, 1, 1, 0, 1, "R1 sync take when free");
    tick(); tick(); tick(); tick();
    // reset while owning
    rst_n = 1'b0;
    expect_at(0, 0, 0, 0, 0, "R8 reset while owning");
    #1;
    n_cmp++;
    if (busy_oe_o !== 1'b0 || own_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R8 async reset oe=%b/0 own=%b/0", busy_oe_o, own_o);
    end
    tick(); tick(); tick();
    if (sb.size() != 0) begin
      n_bad += sb.size();
      $display("FAIL scoreboard left %0d/0 items", sb.size());
    end
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule